// File: doc/BRIEF.md
# Hysteretic Zero-Crossing Detector

This block watches a stream of signed two's-complement samples that arrive with a valid strobe. It keeps a held polarity for the signal. A change of polarity is only accepted after the signal has left a symmetric dead band around zero on the far side. The band's half-width is a runtime input, and a value of zero gives plain sign detection. A candidate crossing must also be backed by a programmable number of consecutive valid samples beyond the opposite threshold before it is confirmed.

Every confirmed crossing gives a single-cycle event with a direction bit, and the held polarity flips at the same time. The block also counts clock cycles between consecutive confirmed rising crossings and reports that count as the period of the signal. The period counter saturates, and an overflow flag stays up until the next rising crossing. Typical users are mains-synchronised control logic and frequency monitors placed after a sampling converter.

Top module: `zc_hyst_detector`

## Requirements
- R1: A valid sample sets the held polarity high only when it is strictly greater than `hyst_mag`, and low only when it is strictly less than minus `hyst_mag`. Samples in the closed band [-hyst_mag, +hyst_mag] never change the polarity.
- R2: After reset the polarity is unknown (`polarity_known` = 0). The first valid sample outside the band sets `polarity_known` and the polarity directly, with no event. Once set, `polarity_known` stays 1 until reset.
- R3: Once the polarity is known, a crossing is confirmed on the clock edge that captures the N-th consecutive valid sample beyond the opposite threshold, where N is `confirm_len`. A value of 0 counts as 1. The outputs show the confirmation in the following cycle.
- R4: A valid sample that is not beyond the opposite threshold while a confirmation is in progress, whether it is inside the band or back on the old side, clears the run. No event follows from the samples before it.
- R5: A confirmed crossing drives `xing_event` high for exactly one cycle. In that same cycle `polarity_q` shows the new polarity, and `xing_rising` shows 1 for a low-to-high crossing and 0 for a high-to-low crossing. `xing_rising` holds its value until the next event.
- R6: With `hyst_mag` = 0, any positive sample counts as high and any negative sample counts as low, while a sample of exactly zero leaves the polarity unchanged.
- R7: Cycles with `smp_valid` low are ignored. They neither change the polarity nor break a confirmation run in progress.
- R8: For every confirmed rising crossing except the first after reset, `period_valid` pulses for one cycle, the cycle after the event. In that cycle `period_cycles` equals the number of clock cycles between the edges that confirmed the previous and the current rising crossings.
- R9: The period counter saturates at 2^PER_W-1. `period_ovf` rises when it saturates and stays high until the next rising-crossing report, which carries 2^PER_W-1 and clears the flag.
- R10: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Signed two's-complement sample |
| hyst_mag | input | DATA_W | Unsigned half-width of the dead band |
| confirm_len | input | CONF_W | Consecutive samples needed to confirm (0 counts as 1) |
| xing_event | output | 1 | One-cycle pulse on a confirmed crossing |
| xing_rising | output | 1 | Direction of the latest crossing, 1 = rising |
| polarity_q | output | 1 | Held polarity, 1 = high |
| polarity_known | output | 1 | Polarity has been established since reset |
| period_cycles | output | PER_W | Cycles between the last two rising crossings |
| period_valid | output | 1 | One-cycle pulse when `period_cycles` updates |
| period_ovf | output | 1 | Period counter saturated |

## Verification
The assertions assume that `hyst_mag` and `confirm_len` only change in cycles where `smp_valid` is low, so that a confirmation run is always judged against one band and one length. The stimulus follows this rule. Every scenario reconfigures only after an idle cycle with the strobe low. All sample values are small compared with the signed range, so neither the sign extension nor the negation of the band limit can wrap.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [1:0] {
        ZONE_MID  = 2'd0,
        ZONE_HIGH = 2'd1,
        ZONE_LOW  = 2'd2
    } zone_e;

endpackage

// File: rtl/zc_band_classify.sv
module zc_band_classify #(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] band,
    output zc_pkg::zone_e     zone
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] s_ext;
    logic signed [EXT_W-1:0] hi_lim;
    logic signed [EXT_W-1:0] lo_lim;

    // Extend by one bit so that the negated band magnitude always fits.
    always_comb begin
        s_ext  = $signed({sample[DATA_W-1], sample});
        hi_lim = $signed({1'b0, band});
        lo_lim = -hi_lim;
        if (s_ext > hi_lim) begin
            zone = zc_pkg::ZONE_HIGH;
        end else if (s_ext < lo_lim) begin
            zone = zc_pkg::ZONE_LOW;
        end else begin
            zone = zc_pkg::ZONE_MID;
        end
    end

endmodule

// File: rtl/zc_confirm.sv
module zc_confirm #(
    parameter int CONF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  zc_pkg::zone_e     zone,
    input  logic [CONF_W-1:0] need_len,
    output logic              pol_known,
    output logic              pol,
    output logic              evt,
    output logic              rising
);
    localparam int RUN_W = CONF_W + 1;

    typedef struct packed {
        logic              known;
        logic              pol;
        logic [CONF_W-1:0] run;
        logic              evt;
        logic              rise;
    } conf_st_t;

    conf_st_t st_d, st_q;

    logic [RUN_W-1:0] need;
    logic [RUN_W-1:0] next_run;
    logic             opposite;

    always_comb begin
        st_d     = st_q;
        st_d.evt = 1'b0;
        need     = (need_len == '0) ? RUN_W'(1) : {1'b0, need_len};
        next_run = {1'b0, st_q.run} + RUN_W'(1);
        opposite = st_q.pol ? (zone == zc_pkg::ZONE_LOW) : (zone == zc_pkg::ZONE_HIGH);

        if (valid) begin
            if (!st_q.known) begin
                // First excursion out of the band just sets the polarity.
                if (zone != zc_pkg::ZONE_MID) begin
                    st_d.known = 1'b1;
                    st_d.pol   = (zone == zc_pkg::ZONE_HIGH);
                    st_d.run   = '0;
                end
            end else if (opposite) begin
                if (next_run >= need) begin
                    st_d.pol  = ~st_q.pol;
                    st_d.rise = ~st_q.pol;
                    st_d.evt  = 1'b1;
                    st_d.run  = '0;
                end else begin
                    st_d.run = next_run[CONF_W-1:0];
                end
            end else begin
                st_d.run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pol_known = st_q.known;
    assign pol       = st_q.pol;
    assign evt       = st_q.evt;
    assign rising    = st_q.rise;

endmodule

// File: rtl/zc_period.sv
module zc_period #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_evt,
    output logic [PER_W-1:0] per_cycles,
    output logic             per_valid,
    output logic             per_ovf
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             armed;
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
        logic             pvld;
        logic             ovf;
    } per_st_t;

    per_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pvld = 1'b0;
        if (rise_evt) begin
            if (st_q.armed) begin
                st_d.per  = st_q.cnt;
                st_d.pvld = 1'b1;
            end
            st_d.armed = 1'b1;
            st_d.cnt   = PER_W'(1);
            st_d.ovf   = 1'b0;
        end else if (st_q.armed && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_cycles = st_q.per;
    assign per_valid  = st_q.pvld;
    assign per_ovf    = st_q.ovf;

endmodule

// File: rtl/zc_hyst_detector.sv
module zc_hyst_detector #(
    parameter int DATA_W = 12,
    parameter int CONF_W = 4,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] hyst_mag,
    input  logic [CONF_W-1:0] confirm_len,
    output logic              xing_event,
    output logic              xing_rising,
    output logic              polarity_q,
    output logic              polarity_known,
    output logic [PER_W-1:0]  period_cycles,
    output logic              period_valid,
    output logic              period_ovf
);
    zc_pkg::zone_e zone;
    logic          rise_evt;

    zc_band_classify #(.DATA_W(DATA_W)) u_band (
        .sample (smp_data),
        .band   (hyst_mag),
        .zone   (zone)
    );

    zc_confirm #(.CONF_W(CONF_W)) u_conf (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (smp_valid),
        .zone      (zone),
        .need_len  (confirm_len),
        .pol_known (polarity_known),
        .pol       (polarity_q),
        .evt       (xing_event),
        .rising    (xing_rising)
    );

    assign rise_evt = xing_event & xing_rising;

    zc_period #(.PER_W(PER_W)) u_per (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_evt   (rise_evt),
        .per_cycles (period_cycles),
        .per_valid  (period_valid),
        .per_ovf    (period_ovf)
    );

endmodule

// File: rtl/zc_hyst_checker.sv
module zc_hyst_checker (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic xing_event,
    input logic xing_rising,
    input logic polarity_q,
    input logic polarity_known,
    input logic period_valid,
    input logic period_ovf
);
    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
        end else begin
            started_q <= 1'b1;
        end
    end

    assert_event_needs_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xing_event |-> polarity_known);

    assert_known_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        polarity_known |=> polarity_known);

    assert_dir_matches_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xing_event |-> (xing_rising == polarity_q));

    assert_pol_flip_has_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $past(polarity_known) && (polarity_q != $past(polarity_q))) |-> xing_event);

    assert_pol_flip_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && (polarity_q != $past(polarity_q))) |-> $past(smp_valid));

    assert_period_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> (started_q && $past(xing_event && xing_rising)));

    assert_ovf_clears_on_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $fell(period_ovf)) |-> period_valid);

endmodule

bind zc_hyst_detector zc_hyst_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .smp_valid      (smp_valid),
    .xing_event     (xing_event),
    .xing_rising    (xing_rising),
    .polarity_q     (polarity_q),
    .polarity_known (polarity_known),
    .period_valid   (period_valid),
    .period_ovf     (period_ovf)
);

// File: tb/tb_zc_hyst_detector.sv
`timescale 1ns/1ps
module tb_zc_hyst_detector;
    localparam int DATA_W = 12;
    localparam int CONF_W = 4;
    localparam int PER_W  = 10;
    localparam int PMAX   = (1 << PER_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic [DATA_W-1:0] hyst_mag = '0;
    logic [CONF_W-1:0] confirm_len = '0;
    logic              xing_event, xing_rising, polarity_q, polarity_known;
    logic [PER_W-1:0]  period_cycles;
    logic              period_valid, period_ovf;

    int n_chk = 0;
    int n_bad = 0;
    int ev_cnt = 0;
    int last_rise = 0;
    int pv_cnt = 0;
    int last_per = 0;
    int exp_per = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zc_hyst_detector #(.DATA_W(DATA_W), .CONF_W(CONF_W), .PER_W(PER_W)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .hyst_mag(hyst_mag), .confirm_len(confirm_len),
        .xing_event(xing_event), .xing_rising(xing_rising),
        .polarity_q(polarity_q), .polarity_known(polarity_known),
        .period_cycles(period_cycles), .period_valid(period_valid),
        .period_ovf(period_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic observe();
        if (xing_event) begin
            ev_cnt++;
            last_rise = int'(xing_rising);
        end
        if (period_valid) begin
            pv_cnt++;
            last_per = int'(period_cycles);
            if (exp_per != 0) chk("R8/R9 period value", last_per, exp_per);
        end
    endtask

    task automatic drive(input int v, input bit vld);
        @(negedge clk);
        smp_data  = DATA_W'(v);
        smp_valid = vld;
        @(posedge clk);
        #1;
        observe();
    endtask

    task automatic push(input int v);
        drive(v, 1'b1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ev_cnt = 0; pv_cnt = 0; exp_per = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk("R10 event", int'(xing_event), 0);
        chk("R10 rising", int'(xing_rising), 0);
        chk("R10 polarity", int'(polarity_q), 0);
        chk("R10 known", int'(polarity_known), 0);
        chk("R10 period", int'(period_cycles), 0);
        chk("R10 period valid", int'(period_valid), 0);
        chk("R10 ovf", int'(period_ovf), 0);
    endtask

    task automatic t_first_excursion();
        hyst_mag = 12'd10; confirm_len = 4'd1;
        push(5);
        chk("R2 known after in-band sample", int'(polarity_known), 0);
        push(50);
        chk("R2 known after excursion", int'(polarity_known), 1);
        chk("R2 polarity set high", int'(polarity_q), 1);
        chk("R2 no event on first excursion", ev_cnt, 0);
    endtask

    task automatic t_band_edges();
        int e0;
        e0 = ev_cnt;
        push(-10); push(-10); push(-10); push(10); push(0);
        chk("R1 band edge holds polarity", int'(polarity_q), 1);
        chk("R1 no event inside band", ev_cnt - e0, 0);
        push(-11);
        chk("R5 event pulse", int'(xing_event), 1);
        chk("R5 falling direction", int'(xing_rising), 0);
        chk("R1 polarity low below -h", int'(polarity_q), 0);
        push(0);
        chk("R5 event lasts one cycle", int'(xing_event), 0);
    endtask

    task automatic t_confirm_run();
        int e0;
        idle(1); confirm_len = 4'd3;
        e0 = ev_cnt;
        push(30); push(30);
        chk("R3 no event before N samples", ev_cnt - e0, 0);
        chk("R3 polarity held before N", int'(polarity_q), 0);
        push(30);
        chk("R3 event on Nth sample", int'(xing_event), 1);
        chk("R3 rising direction", int'(xing_rising), 1);
    endtask

    task automatic t_interrupt();
        int e0;
        e0 = ev_cnt;
        push(-30); push(-30); push(0); push(-30); push(-30);
        chk("R4 broken run gives no event", ev_cnt - e0, 0);
        chk("R4 polarity kept", int'(polarity_q), 1);
        push(-30);
        chk("R4 fresh run confirms", ev_cnt - e0, 1);
        chk("R4 falling after fresh run", last_rise, 0);
        e0 = ev_cnt;
        push(30); push(30); push(-30); push(30); push(30);
        chk("R4 old-side sample clears run", ev_cnt - e0, 0);
    endtask

    task automatic t_len_zero();
        int e0;
        idle(1); confirm_len = 4'd0;
        e0 = ev_cnt;
        push(40);
        chk("R3 length 0 acts as 1", ev_cnt - e0, 1);
        chk("R3 length 0 polarity", int'(polarity_q), 1);
    endtask

    task automatic t_invalid_ignored();
        int e0;
        idle(1); confirm_len = 4'd2;
        e0 = ev_cnt;
        for (int i = 0; i < 4; i++) drive(-100, 1'b0);
        chk("R7 invalid samples no effect", int'(polarity_q), 1);
        chk("R7 invalid samples no event", ev_cnt - e0, 0);
        push(-30);
        drive(30, 1'b0);
        push(-30);
        chk("R7 gap keeps run", ev_cnt - e0, 1);
        chk("R7 falling after gap", int'(polarity_q), 0);
    endtask

    task automatic t_zero_band();
        int e0;
        idle(1); hyst_mag = '0; confirm_len = 4'd1;
        e0 = ev_cnt;
        push(0); push(0);
        chk("R6 zero sample holds", int'(polarity_q), 0);
        push(1);
        chk("R6 +1 rises", ev_cnt - e0, 1);
        push(0);
        chk("R6 zero keeps high", int'(polarity_q), 1);
        push(-1);
        chk("R6 -1 falls", int'(polarity_q), 0);
    endtask

    task automatic t_period();
        do_reset();
        hyst_mag = 12'd10; confirm_len = 4'd1;
        push(-50);
        exp_per = 20;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 9; i++) push(50);
            for (int i = 0; i < 11; i++) push(-50);
        end
        chk("R8 reports in first train", pv_cnt, 3);
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 15; i++) push(50);
            for (int i = 0; i < 22; i++) push(-50);
            exp_per = 37;
        end
        chk("R8 reports in second train", pv_cnt, 6);
        exp_per = 0;
    endtask

    task automatic t_overflow();
        do_reset();
        hyst_mag = 12'd10; confirm_len = 4'd1;
        push(-50); push(50);
        for (int i = 0; i < 500; i++) push(50);
        chk("R9 no overflow yet", int'(period_ovf), 0);
        for (int i = 0; i < 600; i++) push(50);
        chk("R9 overflow flag", int'(period_ovf), 1);
        chk("R9 no report while waiting", pv_cnt, 0);
        push(-50);
        exp_per = PMAX;
        push(50);
        idle(1);
        chk("R9 saturated report seen", pv_cnt, 1);
        chk("R9 overflow cleared", int'(period_ovf), 0);
        exp_per = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_first_excursion();
        t_band_edges();
        t_confirm_run();
        t_interrupt();
        t_len_zero();
        t_invalid_ignored();
        t_zero_band();
        t_period();
        t_overflow();
        finish_run();
    end

endmodule